// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Assembler

This block sits between an instruction fetch stream and a decoder. It takes 16-bit parcels one at a time, in increasing address order, and builds whole instructions from them. The length of each instruction is a prefix code in the low bits of its first parcel. The supported lengths are one, two, three and four parcels, plus a family of long encodings of five to eleven parcels. The block collects exactly the number of parcels the code asks for. It then presents the finished instruction, zero-extended, with the first parcel in the least significant bits. Each result also carries its length in parcels and two flags.

Encodings longer than the output word are still collected and counted, so the stream stays aligned. They are reported with an unsupported flag and an all-zero instruction word. The code point reserved for very long encodings cannot be sized, so the block reports it as illegal after consuming only its first parcel. A flush input drops a half-collected instruction when fetch is redirected.

Both data interfaces are valid/ready. A parcel moves when `in_valid` and `in_ready` are high at a clock edge. A result moves when `out_valid` and `out_ready` are high at a clock edge. The block holds one finished result. While that result waits with `out_ready` low, `in_ready` is low and the result fields do not change. When the result is taken in a given cycle, a new parcel can be accepted in that same cycle, so the steady rate is one parcel per clock. `flush` is a plain control pin.

Top module: `parcel_asm`

## Requirements
- R1: A first parcel whose bits 1:0 are not 2'b11 is a complete instruction. The result has `out_len` 1, and `out_insn` holds the parcel in bits 15:0 with zeros above.
- R2: A first parcel with bits 1:0 equal to 2'b11 and bits 4:2 not equal to 3'b111 starts a two-parcel instruction. The first parcel goes to bits 15:0 of `out_insn` and the second to bits 31:16.
- R3: Low six bits equal to 6'b011111 mean a three-parcel instruction. Low seven bits equal to 7'b0111111 mean a four-parcel instruction. Parcel k (counting from 0) lands in bits 16k+15:16k.
- R4: Low seven bits equal to 7'b1111111, with field n in bits 14:12 not equal to 3'b111, mean an instruction of 5+n parcels. All of its parcels are consumed. The result has `out_unsup` set, `out_len` equal to 5+n, and `out_insn` all zeros.
- R5: Low seven bits equal to 7'b1111111 with n equal to 3'b111 is the reserved code. Only that one parcel is consumed. The result has `out_illegal` set, `out_unsup` clear, `out_len` 1, and `out_insn` all zeros. The next parcel starts a new instruction.
- R6: `out_len` gives the instruction length as a count of 16-bit parcels, from 1 to 11. The flags are clear on any instruction that is neither long nor reserved.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output fields stay unchanged.
- R8: While `flush` is high, `in_ready` is low and any partly collected instruction is discarded. The next parcel accepted is decoded as a first parcel. A finished result already waiting at the output is not affected.
- R9: After reset, `out_valid` is low, `in_ready` is high, and no partial instruction is held.
- R10: Whenever `flush` is low and the output is empty or being taken in that cycle, `in_ready` is high. Results come out in stream order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Parcel can be accepted |
| in_parcel | input | 16 | Next parcel in address order |
| flush | input | 1 | Discard the partial instruction |
| out_valid | output | 1 | Finished result held |
| out_ready | input | 1 | Consumer takes the result |
| out_insn | output | 64 | Assembled instruction, zero-extended |
| out_len | output | 4 | Instruction length in parcels |
| out_unsup | output | 1 | Length exceeds the output word |
| out_illegal | output | 1 | Reserved length code seen |

## Verification
The bench builds the block with its default output width of four parcels. With that width, one-, two-, three- and four-parcel instructions are delivered in full, and every long encoding from five to eleven parcels is on the unsupported path. Random valid gaps and random consumer stalls push the hold-and-release timing and the same-cycle take-and-refill path through many phases. Rare random flushes land in the middle of instructions, so later parcels are decoded out of their original alignment. Directed runs cover the longest encoding, the reserved code followed by a short instruction, and a flush between the two halves of a two-parcel instruction.

// File: rtl/parcel_asm_pkg.sv
package parcel_asm_pkg;
  localparam int PARCEL_W    = 16;
  localparam int MAX_PARCELS = 11;
  localparam int LEN_W       = $clog2(MAX_PARCELS + 1);

  localparam logic [1:0] SHORT_TAG   = 2'b11;
  localparam logic [2:0] WIDE_TAG    = 3'b111;
  localparam logic [2:0] RSVD_FIELD  = 3'b111;
  localparam logic [LEN_W-1:0] LONG_BASE = LEN_W'(5);
endpackage

// File: rtl/pa_len_decode.sv
module pa_len_decode
  import parcel_asm_pkg::*;
(
  input  logic [PARCEL_W-1:0] parcel,
  output logic [LEN_W-1:0]    len_parcels,
  output logic                rsvd_code
);
  always_comb begin
    rsvd_code   = 1'b0;
    len_parcels = LEN_W'(1);
    if (parcel[1:0] != SHORT_TAG) begin
      len_parcels = LEN_W'(1);
    end else if (parcel[4:2] != WIDE_TAG) begin
      len_parcels = LEN_W'(2);
    end else if (!parcel[5]) begin
      len_parcels = LEN_W'(3);
    end else if (!parcel[6]) begin
      len_parcels = LEN_W'(4);
    end else if (parcel[14:12] != RSVD_FIELD) begin
      len_parcels = LONG_BASE + LEN_W'(parcel[14:12]);
    end else begin
      rsvd_code   = 1'b1;
      len_parcels = LEN_W'(1);
    end
  end
endmodule

// File: rtl/pa_collect.sv
module pa_collect
  import parcel_asm_pkg::*;
#(
  parameter int OUT_PARCELS = 4,
  localparam int OUT_W = PARCEL_W * OUT_PARCELS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                take,
  input  logic [PARCEL_W-1:0] parcel,
  input  logic [LEN_W-1:0]    dec_len,
  input  logic                dec_rsvd,
  output logic                done,
  output logic [OUT_W-1:0]    done_insn,
  output logic [LEN_W-1:0]    done_len,
  output logic                done_unsup,
  output logic                done_illegal
);
  localparam logic [LEN_W-1:0] OUT_LEN = LEN_W'(OUT_PARCELS);

  logic                active;
  logic [LEN_W-1:0]    got;
  logic [LEN_W-1:0]    need;
  logic                too_long;
  logic [PARCEL_W-1:0] slot [OUT_PARCELS];
  logic [OUT_W-1:0]    merged;
  logic                single;
  logic                last;

  assign single = dec_rsvd || (dec_len == LEN_W'(1));
  assign last   = active && ((got + LEN_W'(1)) == need);
  assign done   = take && (active ? last : single);

  for (genvar g = 0; g < OUT_PARCELS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (take && ((active ? got : LEN_W'(0)) == LEN_W'(g))) begin
        slot[g] <= parcel;
      end
    end

    always_comb begin
      if (!active) begin
        merged[g*PARCEL_W +: PARCEL_W] = (g == 0) ? parcel : '0;
      end else if (LEN_W'(g) < got) begin
        merged[g*PARCEL_W +: PARCEL_W] = slot[g];
      end else if (LEN_W'(g) == got) begin
        merged[g*PARCEL_W +: PARCEL_W] = parcel;
      end else begin
        merged[g*PARCEL_W +: PARCEL_W] = '0;
      end
    end
  end

  always_comb begin
    done_illegal = !active && dec_rsvd;
    done_unsup   = active && too_long;
    done_len     = active ? need : LEN_W'(1);
    done_insn    = (done_unsup || done_illegal) ? '0 : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      got      <= '0;
      need     <= '0;
      too_long <= 1'b0;
    end else if (flush) begin
      active <= 1'b0;
      got    <= '0;
    end else if (take) begin
      if (!active) begin
        if (!single) begin
          active   <= 1'b1;
          got      <= LEN_W'(1);
          need     <= dec_len;
          too_long <= dec_len > OUT_LEN;
        end
      end else if (last) begin
        active <= 1'b0;
        got    <= '0;
      end else begin
        got <= got + LEN_W'(1);
      end
    end
  end

  // R4: a partial instruction always has gathered fewer parcels than it needs
  a_r4_count_window: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (got >= LEN_W'(1)) && (got < need));

  // R8: a flush leaves no partial instruction behind
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !active);
endmodule

// File: rtl/pa_out_stage.sv
module pa_out_stage
  import parcel_asm_pkg::*;
#(
  parameter int OUT_PARCELS = 4,
  localparam int OUT_W = PARCEL_W * OUT_PARCELS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] load_insn,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_unsup,
  input  logic             load_illegal,
  input  logic             out_ready,
  output logic             free,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_insn,
  output logic [LEN_W-1:0] out_len,
  output logic             out_unsup,
  output logic             out_illegal
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_insn    <= '0;
      out_len     <= '0;
      out_unsup   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      if (load) begin
        out_valid   <= 1'b1;
        out_insn    <= load_insn;
        out_len     <= load_len;
        out_unsup   <= load_unsup;
        out_illegal <= load_illegal;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: a stalled result keeps its contents
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_insn) && $stable(out_len)
      && $stable(out_unsup) && $stable(out_illegal));

  // R7: nothing overwrites a stalled result
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !load);
endmodule

// File: rtl/parcel_asm.sv
module parcel_asm
  import parcel_asm_pkg::*;
#(
  parameter int OUT_PARCELS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [PARCEL_W-1:0]             in_parcel,
  input  logic                            flush,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [PARCEL_W*OUT_PARCELS-1:0] out_insn,
  output logic [LEN_W-1:0]                out_len,
  output logic                            out_unsup,
  output logic                            out_illegal
);
  localparam int OUT_W = PARCEL_W * OUT_PARCELS;
  localparam logic [LEN_W-1:0] OUT_LEN = LEN_W'(OUT_PARCELS);
  localparam logic [LEN_W-1:0] TOP_LEN = LEN_W'(MAX_PARCELS);

  logic             stage_free;
  logic             take;
  logic [LEN_W-1:0] dec_len;
  logic             dec_rsvd;
  logic             c_done;
  logic [OUT_W-1:0] c_insn;
  logic [LEN_W-1:0] c_len;
  logic             c_unsup;
  logic             c_illegal;

  assign in_ready = !flush && stage_free;
  assign take     = in_valid && in_ready;

  pa_len_decode u_dec (
    .parcel      (in_parcel),
    .len_parcels (dec_len),
    .rsvd_code   (dec_rsvd)
  );

  pa_collect #(.OUT_PARCELS(OUT_PARCELS)) u_col (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .take         (take),
    .parcel       (in_parcel),
    .dec_len      (dec_len),
    .dec_rsvd     (dec_rsvd),
    .done         (c_done),
    .done_insn    (c_insn),
    .done_len     (c_len),
    .done_unsup   (c_unsup),
    .done_illegal (c_illegal)
  );

  pa_out_stage #(.OUT_PARCELS(OUT_PARCELS)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (c_done),
    .load_insn    (c_insn),
    .load_len     (c_len),
    .load_unsup   (c_unsup),
    .load_illegal (c_illegal),
    .out_ready    (out_ready),
    .free         (stage_free),
    .out_valid    (out_valid),
    .out_insn     (out_insn),
    .out_len      (out_len),
    .out_unsup    (out_unsup),
    .out_illegal  (out_illegal)
  );

  // R7: back-pressure stops the parcel input
  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: no parcel is accepted during a flush
  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  // R10: the input is open whenever the output can make room
  a_r10_ready_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (!out_valid || out_ready)) |-> in_ready);

  // R5: reserved code yields a single-parcel, empty, illegal result
  a_r5_illegal_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_len == LEN_W'(1)) && !out_unsup && (out_insn == '0));

  // R4: an unsupported result is longer than the output word and carries no bits
  a_r4_unsup_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unsup) |-> (out_len > OUT_LEN) && (out_len <= TOP_LEN) && (out_insn == '0));

  // R6: delivered lengths lie within the output word
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_unsup) |-> (out_len >= LEN_W'(1)) && (out_len <= OUT_LEN));

  // R1: a single-parcel result has nothing above its first parcel
  a_r1_short_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_len == LEN_W'(1))) |-> (out_insn[OUT_W-1:PARCEL_W] == '0));

  // R9: the output is empty in the first cycle after reset
  a_r9_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/parcel_asm_tb_top.sv
module parcel_asm_tb_top;
  localparam int OP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_parcel = '0;
  logic        flush = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_insn;
  logic [3:0]  out_len;
  logic        out_unsup;
  logic        out_illegal;

  always #2 clk = ~clk;

  parcel_asm #(.OUT_PARCELS(OP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_parcel(in_parcel), .flush(flush), .out_valid(out_valid),
    .out_ready(out_ready), .out_insn(out_insn), .out_len(out_len),
    .out_unsup(out_unsup), .out_illegal(out_illegal)
  );

  typedef struct {
    logic [63:0] insn;
    int          len;
    bit          unsup;
    bit          ill;
  } exp_t;

  int          checks = 0;
  int          fails = 0;
  logic [15:0] src_q[$];
  exp_t        exp_q[$];
  bit          m_act = 0;
  int          m_cnt = 0;
  int          m_need = 0;
  bit          m_uns = 0;
  logic [63:0] m_buf = '0;
  bit          prev_stall = 0;
  logic [63:0] prev_insn = '0;
  logic [3:0]  prev_len = '0;
  bit          done_flag = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Length from the prefix rules; 0 marks the reserved code.
  function automatic int ref_len(input logic [15:0] p);
    if (p[1:0] != 2'b11) return 1;
    if (p[4:2] != 3'b111) return 2;
    if (p[5] == 1'b0) return 3;
    if (p[6] == 1'b0) return 4;
    if (p[14:12] == 3'b111) return 0;
    return 5 + int'(p[14:12]);
  endfunction

  task automatic model_take(input logic [15:0] p);
    exp_t e;
    int   l;
    if (!m_act) begin
      l = ref_len(p);
      if (l == 0) begin
        e.insn = '0; e.len = 1; e.unsup = 0; e.ill = 1; exp_q.push_back(e);
      end else if (l == 1) begin
        e.insn = {48'b0, p}; e.len = 1; e.unsup = 0; e.ill = 0; exp_q.push_back(e);
      end else begin
        m_act = 1; m_cnt = 1; m_need = l; m_buf = {48'b0, p}; m_uns = (l > OP);
      end
    end else begin
      if (m_cnt < OP) m_buf[m_cnt*16 +: 16] = p;
      m_cnt++;
      if (m_cnt == m_need) begin
        e.insn = m_uns ? 64'b0 : m_buf; e.len = m_need; e.unsup = m_uns; e.ill = 0;
        exp_q.push_back(e);
        m_act = 0;
      end
    end
  endtask

  task automatic cycle(input bit want_valid, input bit fl, input bit ordy);
    exp_t  e;
    string tag;
    @(negedge clk);
    in_valid  = want_valid && (src_q.size() > 0);
    in_parcel = (src_q.size() > 0) ? src_q[0] : 16'h0;
    flush     = fl;
    out_ready = ordy;
    #1;
    if (prev_stall)
      check(out_valid && out_insn == prev_insn && out_len == prev_len, "R7",
            "stalled result changed", out_insn, prev_insn);
    if (out_valid && !out_ready)
      check(!in_ready, "R7", "in_ready during stall", 64'(in_ready), 64'd0);
    if (fl)
      check(!in_ready, "R8", "in_ready during flush", 64'(in_ready), 64'd0);
    if (!fl && (!out_valid || out_ready))
      check(in_ready, "R10", "in_ready with room", 64'(in_ready), 64'd1);
    prev_stall = out_valid && !out_ready;
    prev_insn  = out_insn;
    prev_len   = out_len;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R10", "unexpected result", out_insn, 64'd0);
      end else begin
        e = exp_q.pop_front();
        tag = e.ill ? "R5" : e.unsup ? "R4" : (e.len == 1) ? "R1" : (e.len == 2) ? "R2" : "R3";
        check(out_insn == e.insn, tag, "instruction word", out_insn, e.insn);
        check(int'(out_len) == e.len, "R6", "length", 64'(out_len), 64'(e.len));
        check(out_unsup == e.unsup, "R4", "unsupported flag", 64'(out_unsup), 64'(e.unsup));
        check(out_illegal == e.ill, "R5", "illegal flag", 64'(out_illegal), 64'(e.ill));
      end
    end
    if (in_valid && in_ready) model_take(src_q.pop_front());
    if (fl) m_act = 0;
  endtask

  // kind: 0 one, 1 two, 2 three, 3 four, 4 long with field n, 5 reserved
  task automatic push_insn(input int kind, input int n);
    logic [15:0] p;
    int          cnt;
    p = 16'($urandom);
    cnt = 1;
    case (kind)
      0: p[1:0] = 2'($urandom_range(2, 0));
      1: begin p[1:0] = 2'b11; p[4:2] = 3'($urandom_range(6, 0)); cnt = 2; end
      2: begin p[5:0] = 6'b011111; cnt = 3; end
      3: begin p[6:0] = 7'b0111111; cnt = 4; end
      4: begin p[6:0] = 7'h7f; p[14:12] = 3'(n); cnt = 5 + n; end
      default: begin p[6:0] = 7'h7f; p[14:12] = 3'b111; end
    endcase
    src_q.push_back(p);
    for (int i = 1; i < cnt; i++) src_q.push_back(16'($urandom));
  endtask

  task automatic drain(input int extra);
    int guard;
    guard = 0;
    while (src_q.size() > 0 && guard < 2000) begin
      cycle(1, 0, 1);
      guard++;
    end
    for (int i = 0; i < extra; i++) cycle(0, 0, 1);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready, "R9", "in_ready after reset", 64'(in_ready), 64'd1);

    // directed: each length class, longest encoding, reserved then short
    push_insn(0, 0); push_insn(1, 0); push_insn(2, 0); push_insn(3, 0);
    push_insn(4, 0); push_insn(4, 6); push_insn(5, 0); push_insn(0, 0);
    push_insn(3, 0);
    drain(4);

    // directed: stalled consumer on back-to-back short instructions
    push_insn(0, 0); push_insn(0, 0); push_insn(1, 0);
    cycle(1, 0, 0);
    repeat (5) cycle(1, 0, 0);
    drain(4);

    // directed: flush between halves of a two-parcel instruction (R8)
    push_insn(1, 0);
    cycle(1, 0, 1);
    src_q.delete();
    cycle(0, 1, 1);
    push_insn(0, 0);
    drain(4);
    check(exp_q.size() == 0, "R8", "results after flush", 64'(exp_q.size()), 64'd0);

    // random stream
    for (int i = 0; i < 2500; i++) begin
      int k;
      k = $urandom_range(99, 0);
      if (k < 30) push_insn(0, 0);
      else if (k < 60) push_insn(1, 0);
      else if (k < 72) push_insn(2, 0);
      else if (k < 84) push_insn(3, 0);
      else if (k < 94) push_insn(4, $urandom_range(6, 0));
      else push_insn(5, 0);
    end
    while (src_q.size() > 0) begin
      cycle($urandom_range(9, 0) < 7, $urandom_range(299, 0) == 0, $urandom_range(9, 0) < 7);
    end
    for (int i = 0; i < 8; i++) cycle(0, 0, 1);
    check(exp_q.size() == 0, "R10", "results left over", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule